// File: doc/BRIEF.md
# Arbitrated Dual-Port Memory Controller

This block puts one single-port memory array behind two requesters. The host side can read and write. The network side can only write. The controller gives the array to one request at a time, in the order in which the requests arrived. When a host request and a network request arrive in the same clock, the network goes first.

Host writes are posted. The address and data go into a one-entry buffer and the host is acknowledged in the next clock, before the array is written. A host access that follows is held off until the buffered write has finished its array cycle.

Each kind of array cycle has its own length in clocks. A host write cycle is the long one. Host reads and network writes use a short cycle of equal length. A cycle that has started always runs to its end. The network port has no buffer: it holds its request, address and data until it is acknowledged.

Top module: `dpm_ctrl`

## Requirements
- R1: While reset is low, and in the clock after it, `host_ack` and `net_ack` are low.
- R2: A host write presented while the posted buffer is empty is acknowledged at the first rising edge that samples it. The acknowledge lasts exactly one clock.
- R3: A second host write presented in the clock right after the first write's acknowledge is acknowledged at edge HWR_CLKS+2. Edges are counted from the edge that first samples the request, which is edge 1. The posted entry holds its address and data until its array cycle ends.
- R4: A host read presented in the clock right after a host write's acknowledge waits for that write to finish. It is acknowledged at edge HWR_CLKS+HRD_CLKS+2 and returns the written data. In general, a host read returns the most recent data written to that address.
- R5: A host read on an idle controller is acknowledged at edge HRD_CLKS+1. `host_rdata` is valid in that same single clock.
- R6: A network write on an idle controller gets a one-clock `net_ack` at edge 2, and its data lands in the array.
- R7: Requests are served in arrival order. A network write to an address that arrives one clock after a host write to the same address leaves the network data in the array. A host read that arrives one clock after a network write waits for it and is acknowledged at edge NWR_CLKS+HRD_CLKS.
- R8: When a host write and a network write to the same address are first sampled at the same edge, the network write is done first, and the host data remains.
- R9: Cycle lengths are fixed and a cycle is never cut short. A network write arriving one clock after an accepted host write is acknowledged at edge HWR_CLKS+1. One arriving one clock after an idle host read is acknowledged at edge HRD_CLKS+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host request, held until `host_ack` |
| host_we | input | 1 | Host direction: 1 = write, 0 = read |
| host_addr | input | AW | Host word address |
| host_wdata | input | DW | Host write data |
| host_ack | output | 1 | One-clock host acknowledge |
| host_rdata | output | DW | Host read data, valid with a read's `host_ack` |
| net_req | input | 1 | Network write request, held until `net_ack` |
| net_addr | input | AW | Network word address |
| net_wdata | input | DW | Network write data |
| net_ack | output | 1 | One-clock network acknowledge, raised when the write is granted |

## Verification
A wrong arbitration order does not show at once. It shows later as the wrong value in a read of an address that both ports wrote, or as an acknowledge that arrives one cycle length too early or too late.

A stuck posted buffer shows as a host acknowledge that is late by a whole write cycle, or a host acknowledge that never comes. A miscounted cycle timer moves every acknowledge after it by the same number of clocks. That is why each acknowledge's latency is checked to the exact edge, and why the array contents are read back after overlapping traffic.

// File: rtl/dpm_pkg.sv
// Package: shared types for the dual-port memory controller.
// Assumes: nothing; only types and a helper function.
package dpm_pkg;

    // Kind of array cycle currently in progress
    typedef enum logic [1:0] {
        CYC_HOST_WR = 2'd0,
        CYC_HOST_RD = 2'd1,
        CYC_NET_WR  = 2'd2
    } cyc_kind_t;

    // Largest of three cycle lengths, used to size the cycle counter
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dpm_host_port.sv
// Module: host side of the controller.
// Accepts one host access at a time. A write is posted into a one-entry
// buffer and acknowledged in the next clock. A read is held until its array
// cycle produces data. A new access is refused while an earlier write is
// still in the buffer, or while a read is open, or during an acknowledge clock.
// Assumes: the host holds req and its fields stable until host_ack and drops
// req during the acknowledge clock.
module dpm_host_port #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          grant_host,
    input  logic          hwr_done,
    input  logic          hrd_last,
    output logic          host_accept,
    output logic          host_wait,
    output logic          host_is_wr,
    output logic [AW-1:0] hold_addr,
    output logic [DW-1:0] hold_data,
    output logic          host_ack
);

    logic buf_valid;
    logic rd_open;
    logic host_ack_q;

    assign host_accept = host_req && !buf_valid && !rd_open && !host_ack_q;
    assign host_ack    = host_ack_q;

    // Capture an accepted access and keep its address and data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr  <= '0;
            hold_data  <= '0;
            host_is_wr <= 1'b0;
        end else if (host_accept) begin
            hold_addr  <= host_addr;
            hold_data  <= host_wdata;
            host_is_wr <= host_we;
        end
    end

    // Track the buffered write, the open read and the wait for a grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_valid <= 1'b0;
            rd_open   <= 1'b0;
            host_wait <= 1'b0;
        end else begin
            if (host_accept) begin
                host_wait <= 1'b1;
                buf_valid <= host_we;
                rd_open   <= !host_we;
            end else begin
                if (grant_host) host_wait <= 1'b0;
                if (hwr_done)   buf_valid <= 1'b0;
                if (hrd_last)   rd_open   <= 1'b0;
            end
        end
    end

    // Acknowledge: at once for a posted write, at data time for a read
    always_ff @(posedge clk) begin
        if (!rst_n) host_ack_q <= 1'b0;
        else        host_ack_q <= (host_accept && host_we) || hrd_last;
    end

    // R2
    host_ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack_q |=> !host_ack_q);

    // R3
    post_buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid && !hwr_done) |=> (buf_valid && $stable(hold_addr) && $stable(hold_data)));

endmodule

// File: rtl/dpm_arbiter.sv
// Module: arbitration and cycle timing for the shared array.
// Serves requests in arrival order. A tie goes to the network. Each granted
// access runs for its fixed number of clocks without preemption. Writes
// land in the array at the last edge of their cycle. A read fetches its data
// at the edge that starts the last clock of its cycle. A new grant may
// start at the same edge at which the previous cycle ends.
// Assumes: every cycle length is at least 2; the network holds its request
// and fields until net_ack.
module dpm_arbiter
    import dpm_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter int HWR_CLKS = 8,
    parameter int HRD_CLKS = 4,
    parameter int NWR_CLKS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_accept,
    input  logic          host_wait,
    input  logic          host_is_wr,
    input  logic [AW-1:0] hold_addr,
    input  logic [DW-1:0] hold_data,
    input  logic          net_req,
    input  logic [AW-1:0] net_addr,
    input  logic [DW-1:0] net_wdata,
    output logic          net_ack,
    output logic          grant_host,
    output logic          hwr_done,
    output logic          hrd_last,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    localparam int MAXC = max3(HWR_CLKS, HRD_CLKS, NWR_CLKS);
    localparam int CW   = (MAXC > 2) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] HWR_LAST = CW'(HWR_CLKS - 1);
    localparam logic [CW-1:0] HRD_LAST = CW'(HRD_CLKS - 1);
    localparam logic [CW-1:0] NWR_LAST = CW'(NWR_CLKS - 1);

    logic          busy;
    logic [CW-1:0] cnt;
    cyc_kind_t     kind;
    logic [AW-1:0] cyc_addr;
    logic [DW-1:0] cyc_data;
    logic          net_pend;
    logic          host_older;
    logic          net_ack_q;

    logic ending, free, net_new, pick_net, pick_host;

    assign ending    = busy && (cnt == '0);
    assign free      = !busy || ending;
    assign net_new   = net_req && !net_pend && !net_ack_q;
    assign pick_net  = free && net_pend && (!host_wait || !host_older);
    assign pick_host = free && host_wait && !pick_net;

    assign grant_host = pick_host;
    assign net_ack    = net_ack_q;
    assign hwr_done   = ending && (kind == CYC_HOST_WR);
    assign hrd_last   = busy && (cnt == CW'(1)) && (kind == CYC_HOST_RD);
    assign mem_we     = ending && (kind != CYC_HOST_RD);
    assign mem_re     = hrd_last;
    assign mem_addr   = cyc_addr;
    assign mem_wdata  = cyc_data;

    // Start, count down and end array cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            kind     <= CYC_NET_WR;
            cyc_addr <= '0;
            cyc_data <= '0;
        end else if (pick_net) begin
            busy     <= 1'b1;
            cnt      <= NWR_LAST;
            kind     <= CYC_NET_WR;
            cyc_addr <= net_addr;
            cyc_data <= net_wdata;
        end else if (pick_host) begin
            busy     <= 1'b1;
            cnt      <= host_is_wr ? HWR_LAST : HRD_LAST;
            kind     <= host_is_wr ? CYC_HOST_WR : CYC_HOST_RD;
            cyc_addr <= hold_addr;
            cyc_data <= hold_data;
        end else if (ending) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Register network requests and the arrival order of the two ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            net_pend   <= 1'b0;
            host_older <= 1'b0;
            net_ack_q  <= 1'b0;
        end else begin
            net_ack_q <= pick_net;
            if (pick_net)     net_pend <= 1'b0;
            else if (net_new) net_pend <= 1'b1;
            if (host_accept)                host_older <= !(net_pend || net_new);
            else if (net_new && host_wait)  host_older <= 1'b1;
        end
    end

    // R6
    net_ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        net_ack_q |=> !net_ack_q);

    // R9
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cnt != '0)) |=> (busy && (cnt == CW'($past(cnt) - 1'b1))));

endmodule

// File: rtl/dpm_mem.sv
// Module: synchronous single-port storage array.
// Writes on an enabled edge; a read enable loads the output register.
// Assumes: write and read enables are never high together.
module dpm_mem #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] arr [DEPTH];

    // Store write data
    always_ff @(posedge clk) begin
        if (we) arr[addr] <= wdata;
    end

    // Load the read register
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= arr[addr];
    end

    // R9
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re));

endmodule

// File: rtl/dpm_ctrl.sv
// Module: top of the arbitrated dual-port memory controller.
// Connects the host side, the arbiter with its cycle timer, and the array.
// Assumes: both requesters hold their requests and fields until acknowledged.
module dpm_ctrl #(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter int HWR_CLKS = 8,
    parameter int HRD_CLKS = 4,
    parameter int NWR_CLKS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_ack,
    output logic [DW-1:0] host_rdata,
    input  logic          net_req,
    input  logic [AW-1:0] net_addr,
    input  logic [DW-1:0] net_wdata,
    output logic          net_ack
);

    logic          host_accept, host_wait, host_is_wr;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;
    logic          grant_host, hwr_done, hrd_last;
    logic          mem_we, mem_re;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    dpm_host_port #(.AW(AW), .DW(DW)) u_host (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .grant_host(grant_host), .hwr_done(hwr_done), .hrd_last(hrd_last),
        .host_accept(host_accept), .host_wait(host_wait), .host_is_wr(host_is_wr),
        .hold_addr(hold_addr), .hold_data(hold_data), .host_ack(host_ack)
    );

    dpm_arbiter #(
        .AW(AW), .DW(DW),
        .HWR_CLKS(HWR_CLKS), .HRD_CLKS(HRD_CLKS), .NWR_CLKS(NWR_CLKS)
    ) u_arb (
        .clk(clk), .rst_n(rst_n),
        .host_accept(host_accept), .host_wait(host_wait), .host_is_wr(host_is_wr),
        .hold_addr(hold_addr), .hold_data(hold_data),
        .net_req(net_req), .net_addr(net_addr), .net_wdata(net_wdata),
        .net_ack(net_ack), .grant_host(grant_host),
        .hwr_done(hwr_done), .hrd_last(hrd_last),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    dpm_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .re(mem_re), .addr(mem_addr), .wdata(mem_wdata),
        .rdata(host_rdata)
    );

endmodule

// File: tb/sim_dpm_ctrl.sv
`timescale 1ns/1ps
module sim_dpm_ctrl;

    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int HWR = 8;
    localparam int HRD = 4;
    localparam int NWR = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_ack;
    logic [DW-1:0] host_rdata;
    logic          net_req = 1'b0;
    logic [AW-1:0] net_addr = '0;
    logic [DW-1:0] net_wdata = '0;
    logic          net_ack;

    int total = 0;
    int bad   = 0;

    logic [DW-1:0] shadow [1 << AW];
    bit            known  [1 << AW];

    always #2 clk = ~clk;

    dpm_ctrl #(.AW(AW), .DW(DW), .HWR_CLKS(HWR), .HRD_CLKS(HRD), .NWR_CLKS(NWR)) u0 (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
        .net_req(net_req), .net_addr(net_addr), .net_wdata(net_wdata), .net_ack(net_ack)
    );

    // Expected acknowledge edges, computed from the requirements
    function automatic int exp_b2b_wr();     return HWR + 2;       endfunction
    function automatic int exp_rd_after_wr(); return HWR + HRD + 2; endfunction
    function automatic int exp_idle_rd();    return HRD + 1;       endfunction
    function automatic int exp_rd_after_net(); return NWR + HRD;   endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           output logic [DW-1:0] rd, output int lat);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d; lat = 0;
        do begin @(negedge clk); lat++; end while (!host_ack);
        rd = host_rdata;
        host_req = 1'b0;
    endtask

    task automatic net_op(input logic [AW-1:0] a, input logic [DW-1:0] d, output int lat);
        net_req = 1'b1; net_addr = a; net_wdata = d; lat = 0;
        do begin @(negedge clk); lat++; end while (!net_ack);
        net_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd, rd2;
        int lat, lat2;
        int unsigned seed;
        seed = $urandom(32'd2024);

        // R1 reset
        idle(3);
        chk("R1 host_ack in reset", {31'd0, host_ack}, 0);
        chk("R1 net_ack in reset", {31'd0, net_ack}, 0);
        rst_n = 1'b1;
        idle(1);
        chk("R1 host_ack after reset", {31'd0, host_ack}, 0);
        chk("R1 net_ack after reset", {31'd0, net_ack}, 0);

        // R2 posted write, R5 idle read
        host_op(1'b1, 8'h10, 16'hA5A5, rd, lat);
        chk("R2 write ack edge", lat, 1);
        idle(1);
        chk("R2 ack one clock", {31'd0, host_ack}, 0);
        idle(12);
        host_op(1'b0, 8'h10, 16'h0, rd, lat);
        chk("R5 idle read edge", lat, exp_idle_rd());
        chk("R5 read data", rd, 16'hA5A5);
        idle(1);
        chk("R5 ack one clock", {31'd0, host_ack}, 0);
        idle(2);

        // R3 back-to-back writes, R4 read right behind a posted write
        host_op(1'b1, 8'h20, 16'h1111, rd, lat);
        chk("R3 first write edge", lat, 1);
        host_op(1'b1, 8'h21, 16'h2222, rd, lat);
        chk("R3 second write edge", lat, exp_b2b_wr());
        host_op(1'b0, 8'h20, 16'h0, rd, lat);
        chk("R4 read after write edge", lat, exp_rd_after_wr());
        chk("R4 read data", rd, 16'h1111);
        host_op(1'b0, 8'h21, 16'h0, rd, lat);
        chk("R4 second address data", rd, 16'h2222);
        idle(2);

        // R6 idle network write
        net_op(8'h80, 16'hBEEF, lat);
        chk("R6 net ack edge", lat, 2);
        idle(1);
        chk("R6 net ack one clock", {31'd0, net_ack}, 0);
        idle(6);
        host_op(1'b0, 8'h80, 16'h0, rd, lat);
        chk("R6 net data landed", rd, 16'hBEEF);
        idle(2);

        // R9 network behind a long host write
        host_op(1'b1, 8'h30, 16'h3333, rd, lat);
        net_op(8'h81, 16'h4444, lat);
        chk("R9 net behind host write", lat, HWR + 1);
        idle(8);

        // R9 network behind an idle host read
        fork
            begin host_op(1'b0, 8'h30, 16'h0, rd, lat); end
            begin idle(1); net_op(8'h82, 16'h5555, lat2); end
        join
        chk("R9 read edge", lat, exp_idle_rd());
        chk("R9 read data", rd, 16'h3333);
        chk("R9 net behind read", lat2, HRD + 1);
        idle(8);

        // R7 read arriving one clock after a network write
        fork
            begin net_op(8'h83, 16'h6666, lat2); end
            begin idle(1); host_op(1'b0, 8'h81, 16'h0, rd, lat); end
        join
        chk("R7 net first edge", lat2, 2);
        chk("R7 read behind net edge", lat, exp_rd_after_net());
        chk("R7 read data", rd, 16'h4444);
        idle(8);

        // R7 arrival order decides final contents
        host_op(1'b1, 8'h40, 16'hAAAA, rd, lat);
        net_op(8'h40, 16'hBBBB, lat);
        idle(20);
        host_op(1'b0, 8'h40, 16'h0, rd, lat);
        chk("R7 later network data kept", rd, 16'hBBBB);
        idle(2);

        // R8 tie: network goes first, host data remains
        fork
            begin host_op(1'b1, 8'h41, 16'hCCCC, rd2, lat); end
            begin net_op(8'h41, 16'hDDDD, lat2); end
        join
        chk("R8 host ack on tie", lat, 1);
        chk("R8 net ack on tie", lat2, 2);
        idle(20);
        host_op(1'b0, 8'h41, 16'h0, rd, lat);
        chk("R8 host data kept", rd, 16'hCCCC);
        idle(2);

        // Random mixed traffic: host in low region, network in high region
        fork
            begin
                for (int i = 0; i < 60; i++) begin
                    logic [AW-1:0] ha;
                    logic [DW-1:0] hd, hr;
                    bit hw;
                    int hl;
                    ha = {4'h0, 4'($urandom_range(0, 15))};
                    hd = DW'($urandom);
                    hw = bit'($urandom_range(0, 1));
                    if (!known[ha]) hw = 1'b1;
                    host_op(hw, ha, hd, hr, hl);
                    if (hw) begin
                        shadow[ha] = hd; known[ha] = 1'b1;
                    end else begin
                        chk("R4 random read data", hr, shadow[ha]);
                    end
                    idle($urandom_range(0, 3));
                end
            end
            begin
                for (int j = 0; j < 40; j++) begin
                    logic [AW-1:0] na;
                    logic [DW-1:0] nd;
                    int nl;
                    na = {4'hC, 4'($urandom_range(0, 15))};
                    nd = DW'($urandom);
                    net_op(na, nd, nl);
                    shadow[na] = nd; known[na] = 1'b1;
                    idle($urandom_range(0, 5));
                end
            end
        join
        idle(20);
        for (int k = 0; k < 16; k++) begin
            logic [AW-1:0] ca;
            ca = {4'hC, 4'(k)};
            if (known[ca]) begin
                host_op(1'b0, ca, 16'h0, rd, lat);
                chk("R6 random net data", rd, shadow[ca]);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule